// File: doc/BRIEF.md
# Level-Aware I/O Interrupt Router

This block sits between a bank of interrupt request lines and a single interrupt delivery path. Each line has its own 64-bit routing entry. The entry sets the vector to send, the delivery mode, the destination mode, the polarity, the trigger mode and a mask. The block keeps a pending bit per line. It sends every unmasked pending request as a one-cycle message on its delivery port.

Edge-triggered lines drop their pending bit as soon as they are sent. Level-triggered lines keep the pending bit and set a per-line in-service flag. While that flag is set, the line is not sent again. When an end-of-interrupt (EOI) vector arrives, every entry whose flag is set and whose vector matches has its flag cleared. If such a line is still asserted and unmasked, it is sent again, so a source that stays active is never lost.

A three-state machine controls the order of events:

- `ST_IDLE`: nothing to send. It moves to `ST_SEND` when a line is ready.
- `ST_SEND`: one line is granted per cycle. It stays in `ST_SEND` while other ready lines remain, and falls back to `ST_IDLE` when none remain.
- `ST_EOI`: entered from any state in the cycle after `eoi_valid`. It applies the latched vector to all entries at once and grants nothing in that cycle. It then goes to `ST_SEND` if any line is ready once the cleared flags are taken into account, and to `ST_IDLE` otherwise.

Another `eoi_valid` keeps the machine in `ST_EOI`.

Top module: `ioint_router`

## Requirements
- R1: After reset every entry reads back as only bit 16 (mask) set, every pending bit and in-service flag is clear, and nothing is delivered.
- R2: Entry fields are placed as follows:
  - vector: bits 7:0
  - delivery mode: bits 10:8
  - destination mode: bit 11
  - polarity: bit 13
  - in-service flag: bit 14
  - trigger mode: bit 15 (0 = edge, 1 = level)
  - mask: bit 16

  A write stores every bit except bit 14, and a read returns the stored bits with bit 14 showing the in-service flag.
- R3: On an edge-mode line, a transition from inactive to active latches the pending bit. One message is sent for it, carrying the entry's vector, delivery mode and destination mode and the line index. The pending bit is cleared when the message is sent.
- R4: On a level-mode line, the pending bit follows the active level. Sending the line sets its in-service flag (read as bit 14 = 1) and leaves the pending bit unchanged.
- R5: A level-mode line whose in-service flag is set is not sent again, however long it stays active.
- R6: An EOI clears the in-service flag of every entry whose vector equals the EOI vector. It leaves the flag of entries with other vectors set.
- R7: After its flag is cleared by an EOI, an unmasked level-mode line that is still active is sent again. A line that has gone inactive is not sent again.
- R8: A masked entry is never sent. A pending edge request on a masked line is kept, and is sent once the mask is cleared.
- R9: When several lines are ready together, they are sent one per cycle on consecutive cycles, lowest line index first.
- R10: A register write can neither set nor clear an in-service flag.
- R11: With polarity 1 a line is active low. With polarity 0 it is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | Interrupt request lines |
| wr_en | input | 1 | Write the entry selected by wr_pin |
| wr_pin | input | PIN_W | Entry index for writes |
| wr_data | input | 64 | Entry write data |
| rd_pin | input | PIN_W | Entry index for reads |
| rd_data | output | 64 | Read data for the entry at rd_pin (combinational) |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| dlv_valid | output | 1 | A delivery message is present this cycle |
| dlv_pin | output | PIN_W | Line index of the message |
| dlv_vector | output | 8 | Vector of the message |
| dlv_mode | output | 3 | Delivery mode of the message |
| dlv_dest_mode | output | 1 | Destination mode of the message |

## Verification
A table of single-line cases covers edge and level lines on low, middle and top indices. It also covers several vector, mode and destination-mode values, so each message field is checked against the entry that produced it.

Directed sequences hold a level line active and then send EOIs in a fixed order: first a non-matching vector, then the matching one, then the matching one after the line drops. This separates "the flag blocks re-delivery" from "a match clears the flag" from "only an active line is sent again".

Other sequences check the following cases:
- masking before and after an EOI;
- an active-low line, which shows the polarity takes effect;
- three lines raised in the same cycle, which fixes the send order and spacing.

// File: rtl/ioint_router_pkg.sv
package ioint_router_pkg;

    localparam int ENTRY_W  = 64;
    localparam int VEC_W    = 8;
    localparam int MODE_W   = 3;
    localparam int VEC_LO   = 0;
    localparam int MODE_LO  = 8;
    localparam int DEST_BIT = 11;
    localparam int POL_BIT  = 13;
    localparam int RIRR_BIT = 14;
    localparam int TRIG_BIT = 15;
    localparam int MASK_BIT = 16;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_EOI  = 2'd2
    } rt_state_e;

    localparam entry_t RESET_ENTRY = entry_t'(1) << MASK_BIT;

    function automatic logic [VEC_W-1:0] f_vec(input entry_t e);
        return e[VEC_LO +: VEC_W];
    endfunction

    function automatic logic [MODE_W-1:0] f_mode(input entry_t e);
        return e[MODE_LO +: MODE_W];
    endfunction

endpackage

// File: rtl/irq_entry_store.sv
module irq_entry_store
    import ioint_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PIN_W-1:0]     wr_pin,
    input  entry_t               wr_data,
    input  logic [NUM_PINS-1:0]  rirr_set,
    input  logic [NUM_PINS-1:0]  rirr_clr,
    input  logic [PIN_W-1:0]     rd_pin,
    output entry_t               cfg_q [NUM_PINS],
    output logic [NUM_PINS-1:0]  rirr_q,
    output entry_t               rd_data
);

    localparam entry_t WR_KEEP = ~(entry_t'(1) << RIRR_BIT);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[i] <= RESET_ENTRY;
            end else if (wr_en && (wr_pin == PIN_W'(i))) begin
                cfg_q[i] <= wr_data & WR_KEEP;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rirr_q[i] <= 1'b0;
            end else if (rirr_set[i]) begin
                rirr_q[i] <= 1'b1;
            end else if (rirr_clr[i]) begin
                rirr_q[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_pin == PIN_W'(i)) begin
                rd_data           = cfg_q[i];
                rd_data[RIRR_BIT] = rirr_q[i];
            end
        end
    end

    // R10
    rirr_no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set == '0) |=> ((rirr_q & ~$past(rirr_q)) == '0));

    // R10
    rirr_no_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_clr == '0) |=> ((~rirr_q & $past(rirr_q)) == '0));

endmodule

// File: rtl/irq_pin_sampler.sv
module irq_pin_sampler #(
    parameter int NUM_PINS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_in,
    input  logic [NUM_PINS-1:0]  pol,
    input  logic [NUM_PINS-1:0]  trig,
    input  logic [NUM_PINS-1:0]  irr_clr,
    output logic [NUM_PINS-1:0]  irr_q
);

    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] act_prev_q;
    logic [NUM_PINS-1:0] active;
    logic [NUM_PINS-1:0] rise;

    assign active = pin_q ^ pol;
    assign rise   = active & ~act_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q      <= '0;
            act_prev_q <= '0;
        end else begin
            pin_q      <= pin_in;
            act_prev_q <= active;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_irr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irr_q[i] <= 1'b0;
            end else if (trig[i]) begin
                irr_q[i] <= active[i];
            end else begin
                irr_q[i] <= (irr_q[i] & ~irr_clr[i]) | rise[i];
            end
        end

        // R3
        edge_irr_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && !irr_q[i] && !rise[i]) |=> !irr_q[i]);
    end

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] gnt,
    output logic [PIN_W-1:0]    idx,
    output logic                any
);

    assign gnt = req & (~req + NUM_PINS'(1));
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = PIN_W'(i);
            end
        end
    end

    // R9
    always_comb begin
        if (!$isunknown(req)) begin
            single_grant_chk: assert ($onehot0(gnt));
        end
    end

endmodule

// File: rtl/ioint_router.sv
module ioint_router
    import ioint_router_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [PIN_W-1:0]    wr_pin,
    input  logic [63:0]         wr_data,
    input  logic [PIN_W-1:0]    rd_pin,
    output logic [63:0]         rd_data,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                dlv_valid,
    output logic [PIN_W-1:0]    dlv_pin,
    output logic [7:0]          dlv_vector,
    output logic [2:0]          dlv_mode,
    output logic                dlv_dest_mode
);

    rt_state_e state_q, state_d;

    entry_t              cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] rirr_v, irr_v;
    logic [NUM_PINS-1:0] mask_v, trig_v, pol_v;
    logic [NUM_PINS-1:0] eoi_match, blocked, ready, ready_after;
    logic [NUM_PINS-1:0] pick_gnt, grant_oh;
    logic [PIN_W-1:0]    pick_idx;
    logic                pick_any, fire;
    logic [VEC_W-1:0]    eoi_vec_q;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_fields
        assign mask_v[i]    = cfg_q[i][MASK_BIT];
        assign trig_v[i]    = cfg_q[i][TRIG_BIT];
        assign pol_v[i]     = cfg_q[i][POL_BIT];
        assign eoi_match[i] = (state_q == ST_EOI) && rirr_v[i] &&
                              (f_vec(cfg_q[i]) == eoi_vec_q);
    end

    assign blocked     = trig_v & rirr_v;
    assign ready       = irr_v & ~mask_v & ~blocked;
    assign ready_after = irr_v & ~mask_v & ~(blocked & ~eoi_match);

    irq_entry_store #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_pin   (wr_pin),
        .wr_data  (wr_data),
        .rirr_set (grant_oh & trig_v),
        .rirr_clr (eoi_match),
        .rd_pin   (rd_pin),
        .cfg_q    (cfg_q),
        .rirr_q   (rirr_v),
        .rd_data  (rd_data)
    );

    irq_pin_sampler #(.NUM_PINS(NUM_PINS)) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pol     (pol_v),
        .trig    (trig_v),
        .irr_clr (grant_oh & ~trig_v),
        .irr_q   (irr_v)
    );

    irq_pick_lowest #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) i_pick (
        .req (ready),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    assign fire     = (state_q == ST_SEND) && pick_any;
    assign grant_oh = fire ? pick_gnt : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = eoi_valid ? ST_EOI :
                               (|ready ? ST_SEND : ST_IDLE);
            ST_SEND: state_d = eoi_valid ? ST_EOI :
                               (|(ready & ~pick_gnt) ? ST_SEND : ST_IDLE);
            ST_EOI:  state_d = eoi_valid ? ST_EOI :
                               (|ready_after ? ST_SEND : ST_IDLE);
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            eoi_vec_q <= '0;
        end else begin
            state_q <= state_d;
            if (eoi_valid) begin
                eoi_vec_q <= eoi_vector;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlv_valid     <= 1'b0;
            dlv_pin       <= '0;
            dlv_vector    <= '0;
            dlv_mode      <= '0;
            dlv_dest_mode <= 1'b0;
        end else begin
            dlv_valid <= fire;
            if (fire) begin
                dlv_pin       <= pick_idx;
                dlv_vector    <= f_vec(cfg_q[pick_idx]);
                dlv_mode      <= f_mode(cfg_q[pick_idx]);
                dlv_dest_mode <= cfg_q[pick_idx][DEST_BIT];
            end
        end
    end

    // R8
    masked_never_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !$past(wr_en)) |-> !mask_v[dlv_pin]);

    // R4
    level_sets_rirr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !$past(wr_en) && trig_v[dlv_pin]) |-> rirr_v[dlv_pin]);

    // R6
    eoi_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EOI) |=> !dlv_valid);

    // R3
    send_from_send_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ($past(state_q) == ST_SEND));

endmodule

// File: tb/test_ioint_router.sv
`timescale 1ns/1ps
module test_ioint_router;

    localparam int N = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic          wr_en = 1'b0;
    logic [PW-1:0] wr_pin = '0;
    logic [63:0]   wr_data = '0;
    logic [PW-1:0] rd_pin = '0;
    logic [63:0]   rd_data;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          dlv_valid;
    logic [PW-1:0] dlv_pin;
    logic [7:0]    dlv_vector;
    logic [2:0]    dlv_mode;
    logic          dlv_dest_mode;

    always #2 clk = ~clk;

    ioint_router #(.NUM_PINS(N)) i_ioint_router (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .wr_en(wr_en), .wr_pin(wr_pin), .wr_data(wr_data),
        .rd_pin(rd_pin), .rd_data(rd_data),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
        .dlv_mode(dlv_mode), .dlv_dest_mode(dlv_dest_mode)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int log_n = 0;
    int log_pin [256];
    int log_vec [256];
    int log_mode [256];
    int log_dest [256];
    int log_cyc [256];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && dlv_valid && log_n < 256) begin
            log_pin[log_n]  = int'(dlv_pin);
            log_vec[log_n]  = int'(dlv_vector);
            log_mode[log_n] = int'(dlv_mode);
            log_dest[log_n] = int'(dlv_dest_mode);
            log_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
    end

    // Table: [31:24] pin, [23:16] vector, [10:8] mode, [4] dest mode, [0] level
    localparam logic [31:0] TBL [6] = '{
        32'h00_20_00_00,
        32'h03_31_01_10,
        32'h07_FE_04_00,
        32'h01_52_00_11,
        32'h05_63_07_01,
        32'h06_00_02_10
    };

    function automatic logic [63:0] mk(input logic [7:0] v, input logic [2:0] m,
                                       input logic d, input logic p,
                                       input logic t, input logic k);
        logic [63:0] e;
        e = '0;
        e[7:0]  = v;
        e[10:8] = m;
        e[11]   = d;
        e[13]   = p;
        e[15]   = t;
        e[16]   = k;
        return e;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int p, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_pin = PW'(p); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    task automatic rd(input int p, output logic [63:0] d);
        rd_pin = PW'(p);
        #1;
        d = rd_data;
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000; wd++) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] d;
        int base;
        run(3);
        rst_n = 1'b1;
        run(10);

        // R1: reset state
        for (int p = 0; p < N; p++) begin
            rd(p, d);
            chk("R1 reset entry", d, 64'h1_0000);
        end
        chk("R1 no delivery after reset", log_n, 0);

        // Table walk: R2 R3 R4 R7
        for (int r = 0; r < 6; r++) begin
            int p;
            logic [7:0] v;
            logic [2:0] m;
            logic dm, lv;
            p  = int'(TBL[r][31:24]);
            v  = TBL[r][23:16];
            m  = TBL[r][10:8];
            dm = TBL[r][4];
            lv = TBL[r][0];
            wr(p, mk(v, m, dm, 1'b0, lv, 1'b1));
            run(3);
            rd(p, d);
            chk("R2 readback", d, mk(v, m, dm, 1'b0, lv, 1'b1));
            wr(p, mk(v, m, dm, 1'b0, lv, 1'b0));
            run(3);
            base = log_n;
            pin_in[p] = 1'b1;
            if (!lv) begin
                run(1);
                pin_in[p] = 1'b0;
            end
            run(12);
            if (lv) begin
                rd(p, d);
                chk("R4 in-service flag set", d[14], 1'b1);
                pin_in[p] = 1'b0;
                run(4);
            end
            chk("R3 one delivery", log_n - base, 1);
            chk("R3 delivered pin", log_pin[base], p);
            chk("R3 delivered vector", log_vec[base], v);
            chk("R3 delivered mode", log_mode[base], m);
            chk("R3 delivered dest mode", log_dest[base], dm);
            if (lv) begin
                eoi(v);
                run(8);
                chk("R7 inactive line not resent", log_n - base, 1);
                rd(p, d);
                chk("R6 flag cleared", d[14], 1'b0);
            end
            wr(p, mk(v, m, dm, 1'b0, lv, 1'b1));
            run(2);
        end

        // Level line held, EOI sequence: R4 R5 R6 R7 R10
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        run(3);
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        base = log_n;
        pin_in[2] = 1'b1;
        run(12);
        chk("R4 level delivered", log_n - base, 1);
        run(20);
        chk("R5 no repeat while flagged", log_n - base, 1);
        eoi(8'h41);
        run(10);
        chk("R6 other vector no resend", log_n - base, 1);
        rd(2, d);
        chk("R6 other vector keeps flag", d[14], 1'b1);
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        run(2);
        rd(2, d);
        chk("R10 write cannot clear flag", d[14], 1'b1);
        eoi(8'h40);
        run(12);
        chk("R7 still-active line resent", log_n - base, 2);
        chk("R7 resent vector", log_vec[base + 1], 8'h40);
        rd(2, d);
        chk("R4 flag set again", d[14], 1'b1);
        pin_in[2] = 1'b0;
        run(4);
        eoi(8'h40);
        run(10);
        chk("R7 dropped line not resent", log_n - base, 2);
        rd(2, d);
        chk("R6 matching EOI clears", d[14], 1'b0);

        // R10: write cannot set flag
        wr(4, mk(8'h44, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1) | 64'h4000);
        run(2);
        rd(4, d);
        chk("R10 write cannot set flag", d, mk(8'h44, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));

        // R8: masked EOI then unmask
        base = log_n;
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        pin_in[2] = 1'b1;
        run(12);
        chk("R8 unmasked level sent", log_n - base, 1);
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        eoi(8'h40);
        run(10);
        chk("R8 masked not resent after EOI", log_n - base, 1);
        rd(2, d);
        chk("R6 EOI clears flag on masked", d[14], 1'b0);
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0));
        run(10);
        chk("R8 sent on unmask", log_n - base, 2);
        pin_in[2] = 1'b0;
        run(4);
        eoi(8'h40);
        wr(2, mk(8'h40, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        run(4);

        // R8: pending edge kept while masked
        base = log_n;
        pin_in[4] = 1'b1;
        run(1);
        pin_in[4] = 1'b0;
        run(10);
        chk("R8 masked edge not sent", log_n - base, 0);
        wr(4, mk(8'h44, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0));
        run(10);
        chk("R8 pending edge sent on unmask", log_n - base, 1);
        chk("R8 pending edge pin", log_pin[base], 4);
        wr(4, mk(8'h44, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1));

        // R11: active-low level line
        pin_in[5] = 1'b1;
        run(3);
        wr(5, mk(8'h75, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1));
        run(4);
        base = log_n;
        wr(5, mk(8'h75, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0));
        run(10);
        chk("R11 high line inactive", log_n - base, 0);
        pin_in[5] = 1'b0;
        run(12);
        chk("R11 low line delivered", log_n - base, 1);
        chk("R11 vector", log_vec[base], 8'h75);
        pin_in[5] = 1'b1;
        run(4);
        eoi(8'h75);
        wr(5, mk(8'h75, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1));
        pin_in[5] = 1'b0;
        run(4);

        // R9: simultaneous edges
        wr(6, mk(8'h16, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(3, mk(8'h13, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        wr(1, mk(8'h11, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
        run(4);
        base = log_n;
        pin_in = 8'b0100_1010;
        run(1);
        pin_in = '0;
        run(12);
        chk("R9 three deliveries", log_n - base, 3);
        chk("R9 first pin", log_pin[base], 1);
        chk("R9 second pin", log_pin[base + 1], 3);
        chk("R9 third pin", log_pin[base + 2], 6);
        chk("R9 consecutive 1", log_cyc[base + 1] - log_cyc[base], 1);
        chk("R9 consecutive 2", log_cyc[base + 2] - log_cyc[base + 1], 1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule